// File: doc/BRIEF.md
# Fan Tachometer Period Measurement Channel

This block measures one fan tachometer signal. It takes an asynchronous tach pulse, or a loopback copy of it, through a two-flop synchronizer and a debounce filter of selectable depth. It picks the qualifying edges, and counts ticks of a power-of-four prescaled clock between successive qualifying edges. Each count is latched into a status word together with an update flag, a full-measurement flag and the live input levels.

A 32-bit control word configures the channel. It holds the channel enable, debounce depth, edge mode, prescaler exponent, a 20-bit threshold, a comparison-inversion bit, a loopback select and the interrupt enable. Every complete measurement is compared against the threshold. A match, or a counter that runs to its ceiling because the fan has stopped, sets a sticky interrupt status. Software reads the status word, acknowledges a fresh value with a one-cycle strobe, and clears the interrupt status with a separate one-cycle pulse.

Top module: `tach_channel`

## Requirements
- R1: Control bit 29 selects the measured source: 0 takes `tach_in`, 1 takes `loop_in`. Status bit 22 shows the selected source after a two-flop synchronizer, two clock edges late.
- R2: Control bits 27:26 set the debounce depth N: code 0 gives N=3, 1 gives N=2, 2 gives N=1 and 3 gives N=0. The filtered level (status bit 23) takes a new synchronized level only after that level has been held for more than N consecutive cycles, so shorter pulses are dropped.
- R3: Control bits 25:24 pick the qualifying edges. Code 0 selects falling edges and code 1 selects rising edges. Codes 2 and 3 select both edges, so each stored value covers half a period.
- R4: The period counter advances once every 4^E input clocks, where E is control bits 23:20.
- R5: On each qualifying edge the tick count since the previous qualifying edge is stored in status bits 19:0, and the update flag (status bit 21) is set. A one-cycle `rd_ack` clears the update flag and leaves the value unchanged. A new value arriving in the same cycle as `rd_ack` wins.
- R6: The full-measurement flag (status bit 20) stays clear for the first value stored after enable, which covers only part of a period. It is set from the second stored value on.
- R7: Each full measurement is compared with the threshold in control bits 19:0. With bit 30 clear, a value greater than the threshold sets the interrupt status. With bit 30 set, a value less than the threshold sets it.
- R8: When no qualifying edge arrives, the counter stops at its all-ones ceiling (CNT_W bits). On reaching the ceiling it stores that value, sets the update and full flags, and sets the interrupt status whatever the comparison sense.
- R9: The interrupt status (status bit 31) is sticky until a one-cycle `irq_clr`. A new event in the same cycle wins. `irq` is the interrupt status gated by control bit 31.
- R10: While control bit 28 (enable) is clear, the count, stored value, update and full flags, interrupt status and prescaler are all held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tach_in | input | 1 | Asynchronous tachometer pulse |
| loop_in | input | 1 | Asynchronous loopback pulse source |
| ctrl_word | input | 32 | Channel configuration word |
| rd_ack | input | 1 | One-cycle strobe that clears the update flag |
| irq_clr | input | 1 | One-cycle pulse that clears the interrupt status |
| status_word | output | 32 | Interrupt status, levels, flags and measured count |
| irq | output | 1 | Interrupt request |

## Verification
The synchronized level reaches status bit 22 two edges after an input change. A source edge reaches the stored value N+4 edges after the input change, where N is the debounce depth. `rd_ack`, `irq_clr` and enable changes take effect at the next edge. Each directed task ends its stimulus with the tach idle and then waits a fixed twelve cycles, or three after a strobe, before it samples at the falling clock edge. That margin exceeds the worst-case pipeline, so every sample lands after the result is due and before any later stimulus. Waveforms use periods that are multiples of the prescale divisor, so each expected count is exact.

// File: rtl/tach_pkg.sv
package tach_pkg;

  localparam int VAL_W = 20;
  localparam int EXP_W = 4;

  typedef enum logic [1:0] {
    EDGE_FALL  = 2'd0,
    EDGE_RISE  = 2'd1,
    EDGE_BOTH  = 2'd2,
    EDGE_BOTH2 = 2'd3
  } edge_mode_t;

  typedef struct packed {
    logic             ien;
    logic             inv;
    logic             lb;
    logic             en;
    logic [1:0]       deb;
    edge_mode_t       mode;
    logic [EXP_W-1:0] exp;
    logic [VAL_W-1:0] thr;
  } tach_ctrl_t;

endpackage

// File: rtl/tach_filter.sv
module tach_filter (
  input  logic       clk,
  input  logic       rst,
  input  logic       src,
  input  logic [1:0] deb_sel,
  output logic       raw_o,
  output logic       deb_o
);
  logic       s1, s2, deb_q;
  logic [1:0] run;
  logic [1:0] need;

  // code 0 is the deepest filter, code 3 is no filter
  assign need = 2'd3 - deb_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      deb_q <= 1'b0;
      run   <= '0;
    end else begin
      s1 <= src;
      s2 <= s1;
      if (s2 == deb_q) begin
        run <= '0;
      end else if (run >= need) begin
        deb_q <= s2;
        run   <= '0;
      end else begin
        run <= run + 2'd1;
      end
    end
  end

  assign raw_o = s2;
  assign deb_o = deb_q;
endmodule

// File: rtl/tach_prescale.sv
module tach_prescale #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             tick
);
  localparam int PRE_W = 2 * ((1 << EXP_W) - 1);

  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] mask;

  assign mask = ~({PRE_W{1'b1}} << {exp_sel, 1'b0});
  assign tick = &(pcnt | ~mask);

  always_ff @(posedge clk) begin
    if (rst || clr) pcnt <= '0;
    else            pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/tach_period.sv
module tach_period #(
  parameter int CNT_W = 20,
  parameter int THR_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             edge_ev,
  input  logic             tick,
  input  logic             rd_ack,
  input  logic             inv,
  input  logic [THR_W-1:0] thr,
  output logic [CNT_W-1:0] value,
  output logic             upd,
  output logic             full,
  output logic             hit
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic [THR_W-1:0] cnt_ext;
  logic             cmp;

  assign cnt_ext = THR_W'(cnt);
  assign cmp     = inv ? (cnt_ext < thr) : (cnt_ext > thr);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt   <= '0;
      value <= '0;
      upd   <= 1'b0;
      full  <= 1'b0;
      armed <= 1'b0;
      hit   <= 1'b0;
    end else begin
      hit <= 1'b0;
      if (rd_ack) upd <= 1'b0;
      if (edge_ev) begin
        value <= cnt;
        cnt   <= tick ? CNT_W'(1) : '0;
        upd   <= 1'b1;
        armed <= 1'b1;
        if (armed) begin
          full <= 1'b1;
          hit  <= cmp;
        end
      end else if (tick && cnt != MAXV) begin
        cnt <= cnt + 1'b1;
        if (cnt == MAXV - 1'b1) begin
          value <= MAXV;
          upd   <= 1'b1;
          full  <= 1'b1;
          hit   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tach_channel.sv
module tach_channel
  import tach_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tach_in,
  input  logic        loop_in,
  input  logic [31:0] ctrl_word,
  input  logic        rd_ack,
  input  logic        irq_clr,
  output logic [31:0] status_word,
  output logic        irq
);
  tach_ctrl_t       c;
  logic             raw, deb, deb_prev;
  logic             rise, fall, edge_ev;
  logic             tick;
  logic [CNT_W-1:0] value;
  logic             upd, full, hit, ists;

  assign c = tach_ctrl_t'(ctrl_word);

  tach_filter u_filter (
    .clk(clk), .rst(rst),
    .src(c.lb ? loop_in : tach_in),
    .deb_sel(c.deb), .raw_o(raw), .deb_o(deb)
  );

  always_ff @(posedge clk) begin
    if (rst) deb_prev <= 1'b0;
    else     deb_prev <= deb;
  end

  assign rise = deb & ~deb_prev;
  assign fall = ~deb & deb_prev;

  always_comb begin
    unique case (c.mode)
      EDGE_FALL: edge_ev = fall;
      EDGE_RISE: edge_ev = rise;
      default:   edge_ev = rise | fall;
    endcase
  end

  tach_prescale #(.EXP_W(EXP_W)) u_pre (
    .clk(clk), .rst(rst), .clr(!c.en), .exp_sel(c.exp), .tick(tick)
  );

  tach_period #(.CNT_W(CNT_W), .THR_W(VAL_W)) u_period (
    .clk(clk), .rst(rst), .en(c.en), .edge_ev(edge_ev), .tick(tick),
    .rd_ack(rd_ack), .inv(c.inv), .thr(c.thr),
    .value(value), .upd(upd), .full(full), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst || !c.en) ists <= 1'b0;
    else if (hit)     ists <= 1'b1;
    else if (irq_clr) ists <= 1'b0;
  end

  assign status_word = {ists, 7'd0, deb, raw, upd, full, VAL_W'(value)};
  assign irq         = ists & c.ien;
endmodule

// File: rtl/tach_channel_chk.sv
module tach_channel_chk (
  input logic        clk,
  input logic        rst,
  input logic        tach_in,
  input logic        loop_in,
  input logic        ctrl_en,
  input logic        ctrl_lb,
  input logic        irq_clr,
  input logic        st_ists,
  input logic        st_deb,
  input logic        st_raw,
  input logic        st_upd,
  input logic        st_full,
  input logic [19:0] st_val
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R1: raw level is the selected source two edges late
  p_raw_sync_r1: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> st_raw == $past(ctrl_lb ? loop_in : tach_in, 2));

  // R2: filtered level only moves to the previous synchronized level
  p_deb_follows_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(st_deb) |-> st_deb == $past(st_raw));

  // R5: stored value moves only with a fresh update or a clear
  p_value_moves_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(st_val) |-> (st_upd || st_val == 20'd0));

  // R6: full flag never rises without a fresh value
  p_full_with_upd_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(st_full) |-> st_upd);

  // R9: interrupt status holds until cleared
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (st_ists && !irq_clr && ctrl_en) |=> st_ists);

  // R10: disable clears measurement state
  p_disable_clear_r10: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |=> (!st_ists && !st_upd && !st_full && st_val == 20'd0));
endmodule

bind tach_channel tach_channel_chk u_chk (
  .clk(clk), .rst(rst), .tach_in(tach_in), .loop_in(loop_in),
  .ctrl_en(ctrl_word[28]), .ctrl_lb(ctrl_word[29]), .irq_clr(irq_clr),
  .st_ists(status_word[31]), .st_deb(status_word[23]), .st_raw(status_word[22]),
  .st_upd(status_word[21]), .st_full(status_word[20]), .st_val(status_word[19:0])
);

// File: tb/tach_channel_bench.sv
module tach_channel_bench;
  localparam int CLK_P = 10;
  localparam int CNT_W = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tach_in = 1'b1;
  logic        loop_in = 1'b1;
  logic [31:0] ctrl_word = '0;
  logic        rd_ack = 1'b0;
  logic        irq_clr = 1'b0;
  logic [31:0] status_word;
  logic        irq;
  logic        use_loop = 1'b0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  tach_channel #(.CNT_W(CNT_W)) u_tach_channel (
    .clk(clk), .rst(rst), .tach_in(tach_in), .loop_in(loop_in),
    .ctrl_word(ctrl_word), .rd_ack(rd_ack), .irq_clr(irq_clr),
    .status_word(status_word), .irq(irq)
  );

  function automatic logic [31:0] mk(input bit ien, input bit inv, input bit lb,
                                     input logic [1:0] deb, input logic [1:0] mode,
                                     input logic [3:0] e, input logic [19:0] thr);
    return {ien, inv, lb, 1'b1, deb, mode, e, thr};
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v);
    if (use_loop) loop_in = v; else tach_in = v;
  endtask

  task automatic restart(input logic [31:0] cw);
    ctrl_word = cw & ~32'h1000_0000;
    cycles(3);
    ctrl_word = cw;
    cycles(1);
  endtask

  // low phase, high, optional low glitch, high again
  task automatic wave(input int lo, input int h1, input int gl, input int h2, input int n);
    for (int i = 0; i < n; i++) begin
      drive(1'b0); cycles(lo);
      drive(1'b1); cycles(h1);
      if (gl > 0) begin drive(1'b0); cycles(gl); drive(1'b1); end
      cycles(h2);
    end
    cycles(12);
  endtask

  task automatic t_reset;
    check("R10 reset status", status_word, 32'h0);
    check("R9 reset irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_edges;
    restart(mk(0, 0, 0, 2'd3, 2'd0, 4'd0, 20'd0));
    wave(30, 70, 0, 0, 4);
    check("R3 falling period", status_word[19:0], 32'd100);
    check("R5 R6 flags", status_word[21:20], 32'd3);
    restart(mk(0, 0, 0, 2'd3, 2'd1, 4'd0, 20'd0));
    wave(30, 70, 0, 0, 4);
    check("R3 rising period", status_word[19:0], 32'd100);
    restart(mk(0, 0, 0, 2'd3, 2'd2, 4'd0, 20'd0));
    wave(30, 70, 0, 0, 4);
    check("R3 both edges half", status_word[19:0], 32'd30);
    rd_ack = 1'b1; cycles(1); rd_ack = 1'b0; cycles(2);
    check("R5 ack clears update", status_word[21], 32'd0);
    check("R5 ack keeps value", status_word[19:0], 32'd30);
  endtask

  task automatic t_debounce;
    restart(mk(0, 0, 0, 2'd0, 2'd0, 4'd0, 20'd0));
    wave(30, 20, 3, 47, 4);
    check("R2 depth3 drops 3-cycle glitch", status_word[19:0], 32'd100);
    restart(mk(0, 0, 0, 2'd0, 2'd0, 4'd0, 20'd0));
    wave(30, 20, 4, 46, 4);
    check("R2 depth3 keeps 4-cycle pulse", status_word[19:0], 32'd50);
    restart(mk(0, 0, 0, 2'd3, 2'd0, 4'd0, 20'd0));
    wave(30, 20, 1, 49, 4);
    check("R2 no filter keeps 1-cycle pulse", status_word[19:0], 32'd50);
  endtask

  task automatic t_prescale;
    restart(mk(0, 0, 0, 2'd3, 2'd0, 4'd1, 20'd0));
    wave(200, 200, 0, 0, 4);
    check("R4 divide by 4", status_word[19:0], 32'd100);
    restart(mk(0, 0, 0, 2'd3, 2'd0, 4'd2, 20'd0));
    wave(400, 400, 0, 0, 3);
    check("R4 divide by 16", status_word[19:0], 32'd50);
  endtask

  task automatic t_threshold;
    restart(mk(1, 0, 0, 2'd3, 2'd0, 4'd0, 20'd99));
    wave(30, 70, 0, 0, 4);
    check("R7 above threshold", status_word[31], 32'd1);
    check("R9 irq enabled", {31'd0, irq}, 32'd1);
    irq_clr = 1'b1; cycles(1); irq_clr = 1'b0; cycles(2);
    check("R9 clear pulse", {status_word[31], irq}, 32'd0);
    restart(mk(1, 0, 0, 2'd3, 2'd0, 4'd0, 20'd100));
    wave(30, 70, 0, 0, 4);
    check("R7 equal no hit", status_word[31], 32'd0);
    restart(mk(0, 1, 0, 2'd3, 2'd0, 4'd0, 20'd101));
    wave(30, 70, 0, 0, 4);
    check("R7 inverted below", status_word[31], 32'd1);
    check("R9 irq masked", {31'd0, irq}, 32'd0);
    restart(mk(1, 1, 0, 2'd3, 2'd0, 4'd0, 20'd100));
    wave(30, 70, 0, 0, 4);
    check("R7 inverted equal no hit", status_word[31], 32'd0);
  endtask

  task automatic t_first;
    restart(mk(0, 0, 0, 2'd3, 2'd0, 4'd0, 20'd0));
    cycles(5);
    wave(30, 70, 0, 0, 1);
    check("R6 first value partial", status_word[21:20], 32'd2);
    wave(30, 70, 0, 0, 1);
    check("R6 second value full", status_word[21:20], 32'd3);
  endtask

  task automatic t_sat;
    restart(mk(1, 1, 0, 2'd3, 2'd0, 4'd0, 20'd0));
    cycles(4200);
    check("R8 saturated value", status_word[19:0], 32'hFFF);
    check("R8 flags and status", {status_word[31], status_word[21:20]}, 32'd7);
    check("R8 irq", {31'd0, irq}, 32'd1);
    ctrl_word[28] = 1'b0; cycles(2);
    check("R10 disabled clear", {status_word[31], status_word[21:0]}, 32'd0);
  endtask

  task automatic t_loop;
    tach_in = 1'b0;
    use_loop = 1'b1;
    restart(mk(0, 0, 1, 2'd3, 2'd0, 4'd0, 20'd0));
    wave(20, 40, 0, 0, 4);
    check("R1 loopback period", status_word[19:0], 32'd60);
    check("R1 raw shows loop source", status_word[22], 32'd1);
    ctrl_word[29] = 1'b0; cycles(3);
    check("R1 raw shows tach source", status_word[22], 32'd0);
    use_loop = 1'b0;
    tach_in = 1'b1;
  endtask

  initial begin
    cycles(4);
    t_reset();
    rst = 1'b0;
    cycles(10);
    t_edges();
    t_debounce();
    t_prescale();
    t_threshold();
    t_first();
    t_sat();
    t_loop();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule